// File: doc/BRIEF.md
# Low-Power Mode Status Flag Register

This block is one control word in a processor's power-management unit. Software uses it to pick a deep-sleep power-down behaviour for each of three domains. It also sets one bit that keeps domain 3 running whatever the processors are doing. Next to these software bits, the word holds four sticky flags that the power sequencer sets. They record that the chip entered stop mode, that the whole system entered standby, and that domain 1 or domain 2 entered its own standby.

Software clears all four flags at once by writing 1 to a command bit. The command bit clears itself and always reads as 0. The flags do not all respond the same way:
- The stop flag is cleared by either reset.
- The system standby flag survives a system reset and is cleared only by power-on reset.
- A domain standby flag ignores the clear command while its domain is still in standby.

The register port has no back-pressure. A write takes effect on the clock edge where `wr_en` is high. Reads are combinational from the stored state. The sequencer's event inputs are single-cycle pulses or levels, sampled on every edge.

Top module: `lpm_flag_reg`

## Requirements
- R1: After power-on reset every bit of `rd_data` is 0, and `pdds_sel` and `keep_d3_run` are 0.
- R2: A write stores `wr_data[2:0]` as the domain 1..3 power-down selections and `wr_data[11]` as the keep-domain-3-running bit. These appear on `rd_data` at the same positions and on `pdds_sel`/`keep_d3_run` from the edge of the write onward.
- R3: The stop flag (`rd_data[5]`) is set after the edge that samples `stop_evt`. It is cleared after a write with `wr_data[9]`=1, and by either reset.
- R4: The system standby flag (`rd_data[6]`) is set by `sys_stby_evt`. It is cleared by a write with `wr_data[9]`=1 or by `por_n`. Asserting `sys_rst_n` alone leaves it unchanged.
- R5: Domain standby flag i (`rd_data[7+i]`, i=0 for domain 1, i=1 for domain 2) is set by `dom_stby_evt[i]`. It is cleared by system or power-on reset. A write with `wr_data[9]`=1 clears it only when `dom_in_stby[i]` is 0 in that cycle.
- R6: A clear command that was refused because the domain was in standby is not remembered. The flag stays 1 after the domain leaves standby until a new clear command is written.
- R7: When a set event and a clear command reach the same flag in the same cycle, the flag ends up 1.
- R8: Bit 9 always reads 0. Every bit other than 0, 1, 2, 5, 6, 7, 8 and 11 always reads 0. Writes to those bits, and to flag bits 5 to 8, have no effect.
- R9: A write with `wr_data[9]`=0 leaves all four flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, async, active low; resets everything |
| sys_rst_n | input | 1 | System reset, async, active low; spares the system standby flag |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Current register value |
| stop_evt | input | 1 | Sequencer: stop mode entered |
| sys_stby_evt | input | 1 | Sequencer: system standby entered |
| dom_stby_evt | input | NUM_DSBY | Sequencer: domain 1/2 standby entered |
| dom_in_stby | input | NUM_DSBY | Domain 1/2 currently in standby |
| pdds_sel | output | NUM_SEL | Deep-sleep power-down selection per domain |
| keep_d3_run | output | 1 | Hold domain 3 in run mode |

## Verification
The hardest state to reach is a refused clear: a domain flag already set, its domain still in standby, and a clear command arriving in exactly that cycle, sometimes together with a new set event. The bench drives every combination of the four events, the clear command and the two standby levels. It does so from both an all-flags-clear and an all-flags-set starting state, so refused clears and set-beats-clear collisions are covered exhaustively. Directed sequences then release standby after a refused clear to show the command was dropped. They also separate the two reset sources.

// File: rtl/lpm_flag_pkg.sv
package lpm_flag_pkg;
  // Bit positions software decodes
  localparam int SEL_LSB      = 0;
  localparam int STOP_BIT     = 5;
  localparam int SYS_SBY_BIT  = 6;
  localparam int DOM_SBY_LSB  = 7;
  localparam int CLR_BIT      = 9;
  localparam int KEEP_RUN_BIT = 11;
  localparam int MIN_DATA_W   = 12;
endpackage

// File: rtl/lpm_flag_cell.sv
module lpm_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic clr_block_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     flag_o <= 1'b0;
    else if (set_i)                 flag_o <= 1'b1;  // set beats clear
    else if (clr_i && !clr_block_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/lpm_ctrl_bits.sv
module lpm_ctrl_bits #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_bits,
  output logic [W-1:0] bits_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bits_o <= '0;
    else if (wr_en) bits_o <= wr_bits;
  end
endmodule

// File: rtl/lpm_readback.sv
module lpm_readback
  import lpm_flag_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_SEL  = 3,
  parameter int NUM_DSBY = 2
) (
  input  logic [NUM_SEL-1:0]  sel_i,
  input  logic                keep_run_i,
  input  logic                stop_i,
  input  logic                sys_sby_i,
  input  logic [NUM_DSBY-1:0] dom_sby_i,
  output logic [DATA_W-1:0]   rd_data
);
  always_comb begin
    rd_data = '0;
    rd_data[SEL_LSB +: NUM_SEL]      = sel_i;
    rd_data[STOP_BIT]                = stop_i;
    rd_data[SYS_SBY_BIT]             = sys_sby_i;
    rd_data[DOM_SBY_LSB +: NUM_DSBY] = dom_sby_i;
    rd_data[KEEP_RUN_BIT]            = keep_run_i;
    // CLR_BIT and all spare bits stay 0
  end
endmodule

// File: rtl/lpm_flag_reg.sv
module lpm_flag_reg
  import lpm_flag_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_SEL  = 3,
  parameter int NUM_DSBY = 2
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                sys_rst_n,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                stop_evt,
  input  logic                sys_stby_evt,
  input  logic [NUM_DSBY-1:0] dom_stby_evt,
  input  logic [NUM_DSBY-1:0] dom_in_stby,
  output logic [NUM_SEL-1:0]  pdds_sel,
  output logic                keep_d3_run
);
  localparam int CTRL_W = NUM_SEL + 1;

  // Any reset clears the system-reset domain; only POR clears the standby flag
  logic rst_any_n;
  logic clr_cmd;
  logic stop_q, sys_sby_q;
  logic [NUM_DSBY-1:0] dom_sby_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic unused_wr_bits;

  assign rst_any_n = por_n & sys_rst_n;
  assign clr_cmd   = wr_en & wr_data[CLR_BIT];
  assign unused_wr_bits = ^{wr_data[DATA_W-1:KEEP_RUN_BIT+1], wr_data[CLR_BIT+1],
                            wr_data[CLR_BIT-1:NUM_SEL]};

  lpm_ctrl_bits #(.W(CTRL_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_any_n),
    .wr_en   (wr_en),
    .wr_bits ({wr_data[KEEP_RUN_BIT], wr_data[SEL_LSB +: NUM_SEL]}),
    .bits_o  (ctrl_q)
  );

  lpm_flag_cell u_stop (
    .clk(clk), .rst_n(rst_any_n), .set_i(stop_evt), .clr_i(clr_cmd),
    .clr_block_i(1'b0), .flag_o(stop_q)
  );

  lpm_flag_cell u_sys_sby (
    .clk(clk), .rst_n(por_n), .set_i(sys_stby_evt), .clr_i(clr_cmd),
    .clr_block_i(1'b0), .flag_o(sys_sby_q)
  );

  for (genvar i = 0; i < NUM_DSBY; i++) begin : g_dom
    lpm_flag_cell u_dom_sby (
      .clk(clk), .rst_n(rst_any_n), .set_i(dom_stby_evt[i]), .clr_i(clr_cmd),
      .clr_block_i(dom_in_stby[i]), .flag_o(dom_sby_q[i])
    );
  end

  lpm_readback #(.DATA_W(DATA_W), .NUM_SEL(NUM_SEL), .NUM_DSBY(NUM_DSBY)) u_rd (
    .sel_i      (ctrl_q[NUM_SEL-1:0]),
    .keep_run_i (ctrl_q[CTRL_W-1]),
    .stop_i     (stop_q),
    .sys_sby_i  (sys_sby_q),
    .dom_sby_i  (dom_sby_q),
    .rd_data    (rd_data)
  );

  assign pdds_sel    = ctrl_q[NUM_SEL-1:0];
  assign keep_d3_run = ctrl_q[CTRL_W-1];
endmodule

// File: rtl/lpm_flag_chk.sv
module lpm_flag_chk
  import lpm_flag_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_SEL  = 3,
  parameter int NUM_DSBY = 2
) (
  input logic                clk,
  input logic                por_n,
  input logic                sys_rst_n,
  input logic                wr_en,
  input logic [DATA_W-1:0]   wr_data,
  input logic [DATA_W-1:0]   rd_data,
  input logic                stop_evt,
  input logic                sys_stby_evt,
  input logic [NUM_DSBY-1:0] dom_stby_evt,
  input logic [NUM_DSBY-1:0] dom_in_stby,
  input logic [NUM_SEL-1:0]  pdds_sel,
  input logic                keep_d3_run
);
  assert_sel_write_R2: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    wr_en |=> (pdds_sel == $past(wr_data[NUM_SEL-1:0])) && (keep_d3_run == $past(wr_data[KEEP_RUN_BIT])));

  assert_stop_set_R3: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    stop_evt |=> rd_data[STOP_BIT]);

  assert_stop_clear_R3: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (wr_en && wr_data[CLR_BIT] && !stop_evt) |=> !rd_data[STOP_BIT]);

  assert_sys_set_R4: assert property (@(posedge clk) disable iff (!por_n)
    (sys_stby_evt && sys_rst_n) |=> rd_data[SYS_SBY_BIT]);

  assert_dom_hold_R5: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (rd_data[DOM_SBY_LSB] && dom_in_stby[0]) |=> rd_data[DOM_SBY_LSB]);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (wr_en && wr_data[CLR_BIT] && sys_stby_evt) |=> rd_data[SYS_SBY_BIT]);

  assert_no_write_R9: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (wr_en && !wr_data[CLR_BIT] && !stop_evt) |=> $stable(rd_data[STOP_BIT]));

  assert_spare_zero_R8: assert property (@(posedge clk)
    (rd_data[CLR_BIT] == 1'b0) && (rd_data[DATA_W-1:KEEP_RUN_BIT+1] == '0) &&
    (rd_data[CLR_BIT+1] == 1'b0) && (rd_data[STOP_BIT-1:NUM_SEL] == '0));
endmodule

bind lpm_flag_reg lpm_flag_chk #(.DATA_W(DATA_W), .NUM_SEL(NUM_SEL), .NUM_DSBY(NUM_DSBY)) u_chk (.*);

// File: tb/tb_lpm_flag_reg.sv
module tb_lpm_flag_reg;
  localparam int DW = 32;
  logic clk = 1'b0;
  logic por_n = 1'b0, sys_rst_n = 1'b0, wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic stop_evt = 1'b0, sys_stby_evt = 1'b0;
  logic [1:0] dom_stby_evt = '0, dom_in_stby = '0;
  logic [2:0] pdds_sel;
  logic keep_d3_run;
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  lpm_flag_reg dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_data = '0; stop_evt = 1'b0; sys_stby_evt = 1'b0; dom_stby_evt = '0;
  endtask

  // Drive after a negedge, let one posedge pass, return at the next negedge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    wr_en = 1'b1; wr_data = d; step(); idle();
  endtask

  function automatic logic [3:0] flags();
    return rd_data[8:5];
  endfunction

  initial begin
    @(negedge clk); @(negedge clk);
    por_n = 1'b1; sys_rst_n = 1'b1;
    idle();
    step();
    chk("R1 reset rd_data", rd_data, '0);
    chk("R1 reset outputs", {28'd0, keep_d3_run, pdds_sel}, '0);

    // R2: all combinations of the software bits
    for (int k = 0; k < 16; k++) begin
      logic [DW-1:0] d;
      d = '0; d[2:0] = k[2:0]; d[11] = k[3];
      wr(d);
      chk("R2 readback", rd_data, d);
      chk("R2 outputs", {28'd0, keep_d3_run, pdds_sel}, {28'd0, k[3:0]});
    end

    // R8: all-ones write: only software bits stick, clear reads 0
    wr('1);
    chk("R8 all-ones write", rd_data, 32'h0000_0807);
    // R8: flag bits not writable
    wr(32'h0000_01E0);
    chk("R8 flag bits ignore writes", rd_data, '0);

    // Exhaustive sweep: events x clear x standby levels x start state
    for (int p = 0; p < 256; p++) begin
      logic [3:0] pre, exp_f, ev;
      logic clr;
      logic [1:0] sb;
      dom_in_stby = 2'b00;
      if (p[7]) begin
        stop_evt = 1'b1; sys_stby_evt = 1'b1; dom_stby_evt = 2'b11; step(); idle();
        pre = 4'hF;
      end else begin
        wr(32'h200);
        pre = 4'h0;
      end
      ev  = p[3:0];
      clr = p[4];
      sb  = p[6:5];
      stop_evt = ev[0]; sys_stby_evt = ev[1]; dom_stby_evt = ev[3:2];
      dom_in_stby = sb;
      wr_en = clr; wr_data = clr ? 32'h200 : 32'h0;
      step(); idle();
      for (int f = 0; f < 4; f++) begin
        if (ev[f]) exp_f[f] = 1'b1;                          // R7 set wins
        else if (clr && (f < 2 || !sb[f-2])) exp_f[f] = 1'b0; // R3 R4 R5
        else exp_f[f] = pre[f];                              // R9 / refused
      end
      chk("R3 R4 R5 R7 R9 sweep", {28'd0, flags()}, {28'd0, exp_f});
    end
    dom_in_stby = 2'b00;

    // R9: write without clear keeps flags
    stop_evt = 1'b1; sys_stby_evt = 1'b1; dom_stby_evt = 2'b11; step(); idle();
    wr(32'h0000_0005);
    chk("R9 write keeps flags", {28'd0, flags()}, 32'hF);

    // R4: system reset spares system standby flag
    @(negedge clk); sys_rst_n = 1'b0; step(); sys_rst_n = 1'b1; step();
    chk("R4 sys reset keeps standby flag", rd_data, 32'h0000_0040);
    @(negedge clk); por_n = 1'b0; step(); por_n = 1'b1; step();
    chk("R4 por clears standby flag", rd_data, '0);

    // R6: refused clear is dropped
    dom_in_stby = 2'b01; dom_stby_evt = 2'b01; step(); idle();
    wr(32'h200);
    chk("R6 refused clear", {28'd0, flags()}, 32'h4);
    dom_in_stby = 2'b00; step(); step(); step();
    chk("R6 not remembered", {28'd0, flags()}, 32'h4);
    wr(32'h200);
    chk("R6 later clear", {28'd0, flags()}, 32'h0);
    // R3: stop flag cleared by system reset
    stop_evt = 1'b1; step(); idle();
    @(negedge clk); sys_rst_n = 1'b0; step(); sys_rst_n = 1'b1; step();
    chk("R3 sys reset clears stop", rd_data, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule